// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Separate Wake Gating

This block collects sixteen interrupt lines that may come from unrelated clock domains and brings each one into the system clock domain through a two-flop synchronizer. A rising edge on a synchronized line marks that line as pending. It stays pending until the core acknowledges it. Among the lines that are pending and allowed to interrupt, the lowest-numbered one wins. The block presents it to the core as a request strobe and a vector address equal to the line number.

Two per-line masks are held in the block, and both reset to zero. The interrupt mask decides which pending lines can raise the request and take part in vector selection. The wake mask decides which pending lines can raise the wake output, which releases a halted core. The two masks are independent, so a line can wake the core without interrupting it, or the other way round. Software writes each mask whole through a one-cycle write port. The core pulses an acknowledge input to retire the line whose vector is currently shown.

Top module: `irqc_top`

## Requirements
- R1: Each input line passes through two synchronizing flops, then an edge register. A line that goes high before clock edge k makes a request visible on the outputs just after edge k+2, provided the line is unmasked.
- R2: A line becomes pending on a low-to-high transition of its synchronized level. It stays pending after the input falls, until it is acknowledged.
- R3: The priority is fixed. When several enabled lines are pending and a new choice is made, the lowest line index wins.
- R4: The vector output is the 4-bit binary index of the chosen line. It reads 0 when no enabled line is pending.
- R5: The request output is high exactly when at least one line is both pending and set in the interrupt mask. It is a registered output.
- R6: The wake output is high exactly when at least one line is both pending and set in the wake mask. It does not depend on the interrupt mask.
- R7: While the request is high, the vector holds its value even if a higher-priority line becomes pending. It changes only after an acknowledge, or when the shown line stops being pending and enabled.
- R8: An acknowledge pulse while the request is high clears the pending bit of the shown line only. An acknowledge while the request is low has no effect.
- R9: If a new rising edge on the acknowledged line arrives in the same cycle as its acknowledge, the line stays pending.
- R10: Both masks are zero after reset. A write with address 0 loads the interrupt mask, and a write with address 1 loads the wake mask. Either write takes effect at the next clock edge.
- R11: Clearing a mask bit keeps that line's pending bit. The line drops out of the outputs at once, and it returns when the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 16 | Asynchronous interrupt lines, one per source |
| wr_en_i | input | 1 | Mask write strobe |
| wr_addr_i | input | 1 | Mask select: 0 interrupt mask, 1 wake mask |
| wr_data_i | input | 16 | New mask value |
| ack_i | input | 1 | Core acknowledge pulse for the shown vector |
| req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 4 | Vector address of the chosen line |
| wake_o | output | 1 | Halt-release signal to the core |

## Verification
Single lines raised with masks off and then on show whether pending state survives masking. Staggered arrivals show whether the shown vector is held. Simultaneous arrivals test the priority order. Lines set in only one mask show that request and wake are gated separately. An acknowledge timed to land in the same cycle as a fresh edge on the same line tells a lost edge apart from a kept one. An acknowledge sent while the request is low tests that an idle acknowledge does nothing. A behavioural model in the bench is compared against the request, wake and vector outputs on every clock, across all of these patterns.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the interrupt controller.
package irqc_pkg;
    localparam int unsigned IRQC_LINES = 16;

    // Mask select values on the write port.
    typedef enum logic {
        MSEL_IRQ  = 1'b0,
        MSEL_WAKE = 1'b1
    } mask_sel_e;
endpackage

// File: rtl/irqc_sync.sv
// Multi-flop synchronizer bank. Brings every asynchronous line into the clk
// domain. Assumes each input pulse is wider than one clk period.
module irqc_sync #(
    parameter int unsigned N_LINES = 16,
    parameter int unsigned STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] async_i,
    output logic [N_LINES-1:0] sync_o
);
    logic [N_LINES-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Shift through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end

            // R1
            sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> stage_q[s] == $past(stage_q[s-1]));
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_pend.sv
// Edge detection and pending bits. Sets a bit on a rising synchronized
// level and clears it on a clear request. A set wins over a clear in the
// same cycle. Also exposes the next-state value for the output stage.
module irqc_pend #(
    parameter int unsigned N_LINES = 16,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] sync_i,
    input  logic               clr_en_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [N_LINES-1:0] pend_o,
    output logic [N_LINES-1:0] pend_nxt_o
);
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] rise;

    assign rise = sync_i & ~prev_q;

    // Next pending state: clear the acknowledged line, then apply new edges.
    always_comb begin
        pend_nxt_o = pend_q;
        if (clr_en_i) pend_nxt_o[clr_idx_i] = 1'b0;
        pend_nxt_o = pend_nxt_o | rise;
    end

    // Register the previous level and the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= sync_i;
            pend_q <= pend_nxt_o;
        end
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        // R2
        edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> pend_q[i]);
    end

    // R8
    ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !rise[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]);

    // R9
    ack_edge_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && rise[clr_idx_i]) |=> pend_q[$past(clr_idx_i)]);
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority encoder: lowest set index wins. Returns index 0 when
// nothing is set. Purely combinational.
module irqc_prio #(
    parameter int unsigned N_LINES = 16,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] act_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);
    // Scan from the lowest-priority end so the lowest index is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (act_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |act_i;
    end
endmodule

// File: rtl/irqc_top.sv
// Interrupt controller top. Holds the interrupt and wake masks, drives the
// registered request, wake and vector outputs, and holds the vector while a
// request is outstanding. Assumes ack_i is a single-cycle pulse from the core.
module irqc_top #(
    parameter int unsigned N_LINES = irqc_pkg::IRQC_LINES,
    localparam int unsigned VEC_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic               wr_en_i,
    input  logic               wr_addr_i,
    input  logic [N_LINES-1:0] wr_data_i,
    input  logic               ack_i,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               wake_o
);
    import irqc_pkg::*;

    logic [N_LINES-1:0] sync_w;
    logic [N_LINES-1:0] pend_w, pend_nxt_w;
    logic [N_LINES-1:0] irq_msk_q, wake_msk_q;
    logic [N_LINES-1:0] irq_msk_nxt, wake_msk_nxt;
    logic [N_LINES-1:0] act_nxt;
    logic [VEC_W-1:0]   win_idx;
    logic               win_any;
    logic               clr_en;
    logic               hold_vec;

    irqc_sync #(.N_LINES(N_LINES), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_i),
        .sync_o  (sync_w)
    );

    assign clr_en = ack_i & req_o;

    irqc_pend #(.N_LINES(N_LINES)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_w),
        .clr_en_i   (clr_en),
        .clr_idx_i  (vec_o),
        .pend_o     (pend_w),
        .pend_nxt_o (pend_nxt_w)
    );

    // Next mask values from the write port.
    always_comb begin
        irq_msk_nxt  = irq_msk_q;
        wake_msk_nxt = wake_msk_q;
        if (wr_en_i) begin
            if (mask_sel_e'(wr_addr_i) == MSEL_WAKE) wake_msk_nxt = wr_data_i;
            else                                     irq_msk_nxt  = wr_data_i;
        end
    end

    assign act_nxt = pend_nxt_w & irq_msk_nxt;

    irqc_prio #(.N_LINES(N_LINES)) u_prio (
        .act_i (act_nxt),
        .idx_o (win_idx),
        .any_o (win_any)
    );

    // Keep the shown vector while it is still requesting and not acknowledged.
    assign hold_vec = req_o & ~ack_i & act_nxt[vec_o];

    // Register the masks and the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_msk_q  <= '0;
            wake_msk_q <= '0;
            req_o      <= 1'b0;
            wake_o     <= 1'b0;
            vec_o      <= '0;
        end else begin
            irq_msk_q  <= irq_msk_nxt;
            wake_msk_q <= wake_msk_nxt;
            req_o      <= win_any;
            wake_o     <= |(pend_nxt_w & wake_msk_nxt);
            if (!hold_vec) vec_o <= win_idx;
        end
    end

    // R5
    req_vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (pend_w[vec_o] && irq_msk_q[vec_o]));

    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && !wr_en_i) |=> $stable(vec_o));

    // R10
    no_req_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_msk_q == '0) |-> !req_o);

    // R6
    no_wake_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_msk_q == '0) |-> !wake_o);

    // R4
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |-> (vec_o == '0));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ack = 1'b0;
    logic        req, wake;
    logic [3:0]  vec;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
        .req_o(req), .vec_o(vec), .wake_o(wake)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    logic [15:0] m_s1, m_s2, m_s3, m_pend, m_en, m_run;
    bit          m_req, m_wake;
    int          m_vec;
    always @(posedge clk) begin
        logic [15:0] rise, pn, en_n, run_n, act;
        bit hold;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pend = 0; m_en = 0; m_run = 0;
            m_req = 0; m_wake = 0; m_vec = 0;
        end else begin
            rise = m_s2 & ~m_s3;
            en_n = m_en; run_n = m_run;
            if (wr_en) begin
                if (wr_addr) run_n = wr_data; else en_n = wr_data;
            end
            pn = m_pend;
            if (ack && m_req) pn[m_vec] = 1'b0;
            pn = pn | rise;
            act = pn & en_n;
            hold = m_req && !ack && act[m_vec];
            if (!hold) begin
                m_vec = 0;
                for (int i = 15; i >= 0; i--) if (act[i]) m_vec = i;
            end
            m_req = (act != 0);
            m_wake = ((pn & run_n) != 0);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq;
            m_pend = pn; m_en = en_n; m_run = run_n;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(req == m_req, "R5 model req", int'(req), int'(m_req));
            check(wake == m_wake, "R6 model wake", int'(wake), int'(m_wake));
            check(int'(vec) == m_vec, "R4 model vec", int'(vec), m_vec);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10: reset state
        check(req == 0 && wake == 0 && vec == 0, "R10 reset outputs", int'(req), 0);

        // R11: line pending while masked, shows when enabled
        irq[5] = 1'b1;
        tick(4);
        check(req == 0, "R10 masked after reset", int'(req), 0);
        wr(1'b0, 16'hFFFF);
        check(req == 1 && vec == 5, "R11 pending kept through mask", int'(vec), 5);

        // R7: higher lines arrive, vector held
        irq[3] = 1'b1; irq[9] = 1'b1;
        tick(4);
        check(vec == 5, "R7 vector held", int'(vec), 5);
        pulse_ack();
        check(req == 1 && vec == 3, "R3 next winner", int'(vec), 3);
        pulse_ack();
        check(vec == 9, "R8 ack clears shown line", int'(vec), 9);
        pulse_ack();
        check(req == 0 && vec == 0, "R4 idle vector", int'(vec), 0);
        irq = '0;
        tick(3);

        // R1: latency from line to request
        irq[2] = 1'b1;
        tick(1);
        check(req == 0, "R1 not after edge 1", int'(req), 0);
        tick(1);
        check(req == 0, "R1 not after edge 2", int'(req), 0);
        tick(1);
        check(req == 1 && vec == 2, "R1 visible after edge 3", int'(vec), 2);
        irq[2] = 1'b0;
        tick(4);
        check(req == 1, "R2 pending after line falls", int'(req), 1);
        pulse_ack();
        check(req == 0, "R8 ack retires line", int'(req), 0);

        // R3: simultaneous arrival
        irq[12] = 1'b1; irq[1] = 1'b1;
        tick(4);
        check(vec == 1, "R3 lowest index wins", int'(vec), 1);
        irq = '0;
        pulse_ack();
        check(vec == 12, "R3 second winner", int'(vec), 12);
        pulse_ack();
        tick(2);

        // R6: wake independent of interrupt mask
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'h0080);
        irq[7] = 1'b1;
        tick(4);
        check(wake == 1 && req == 0, "R6 wake without request", int'(wake), 1);
        wr(1'b0, 16'hFFFF);
        check(req == 1 && vec == 7, "R10 enable mask write", int'(vec), 7);
        wr(1'b1, 16'h0000);
        check(wake == 0 && req == 1, "R11 wake mask cleared", int'(wake), 0);
        wr(1'b0, 16'h0000);
        check(req == 0, "R11 request drops at once", int'(req), 0);
        pulse_ack();
        wr(1'b0, 16'hFFFF);
        check(req == 1 && vec == 7, "R8 idle ack ignored", int'(vec), 7);
        pulse_ack();
        check(req == 0, "R8 ack after re-enable", int'(req), 0);
        irq = '0;
        tick(3);

        // R9: new edge on the same cycle as its acknowledge
        irq[4] = 1'b1;
        tick(4);
        check(vec == 4 && req == 1, "R9 setup", int'(vec), 4);
        irq[4] = 1'b0;
        tick(4);
        irq[4] = 1'b1;
        tick(2);
        pulse_ack();
        check(req == 1 && vec == 4, "R9 edge survives ack", int'(req), 1);
        pulse_ack();
        check(req == 0, "R9 cleanup", int'(req), 0);
        irq = '0;
        tick(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule